// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block watches every I/O request the core issues and decides whether it is served on chip or sent out as an external bus cycle. Two adjacent byte ports are reserved, an index port and a data port. A byte write of a recognised register number to the index port arms the data port for one access. That next access reads or writes a small byte-wide configuration register file and causes no external cycle. Any other request is flagged for the external bus. This includes wider accesses that touch either port, data-port accesses without a fresh arm, index reads and unknown register numbers.

The register file has up to sixteen writable entries numbered upward from C0h. It also has two read-only identification bytes at FEh and FFh, whose values are set by parameters. An optional trap detector flags any request whose start address falls inside a configurable legacy window, as long as the runtime enable is high. The trap detector is removed when its parameter is off.

All results appear on registered outputs one clock after the request cycle.

Top module: `cfg_index_port`

## Requirements
- R1: After reset, ext_cycle and trap_flag are 0, rsp_rdata is 0, the data port is not armed, and every writable entry reads 00h.
- R2: A byte write (req_size 0) to port 22h whose low data byte is in C0h–CFh or is FEh/FFh arms the data port, latches that number and raises no ext_cycle.
- R3: A write to port 22h with any other number raises ext_cycle, disarms the data port and leaves every register unchanged.
- R4: Any read of port 22h raises ext_cycle and disarms the data port.
- R5: When armed, a byte access to port 23h raises no ext_cycle. A write stores the low data byte in the selected entry. A read returns the entry in rsp_rdata[7:0] with the upper bits 0. Both results appear one cycle after the request.
- R6: A port 23h access made while not armed raises ext_cycle and modifies no register.
- R7: Every port 23h access disarms the data port, so a second access with no new index write is forwarded externally.
- R8: Entries FEh and FFh read the values of the ID_LO and ID_HI parameters, and writes to them are ignored without an external cycle.
- R9: A 16-bit (req_size 1) or 32-bit (req_size 2) access whose byte span covers 22h or 23h raises ext_cycle and disarms the data port.
- R10: A request to any address whose span misses 22h–23h raises ext_cycle and leaves the armed state unchanged.
- R11: With trap_en high, a request whose start address is in 3B0h–3DFh raises trap_flag for one cycle. Outside that window, or with trap_en low, trap_flag stays 0. The request itself is still forwarded.
- R12: ext_cycle is high for exactly one cycle per forwarded request and is low in any cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | One-cycle I/O request strobe |
| req_addr | input | ADDR_W (16) | I/O start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit |
| req_wdata | input | 8 | Byte lane 0 of the write data |
| trap_en | input | 1 | Runtime enable for the legacy-window trap |
| rsp_rdata | output | DATA_W (32) | Read data from an internal register, else 0 |
| ext_cycle | output | 1 | Request must run as an external I/O cycle |
| trap_flag | output | 1 | Request hit the legacy trap window |

## Verification
The bench keeps the default port numbers, the full sixteen writable entries and the trap window, and it enables the trap detector. It overrides ID_LO and ID_HI with distinct non-zero bytes, so that a read of either identification entry cannot be confused with a reset value or with the other entry. With the full window, both edge entries C0h and CFh can be reached, along with the exact trap limits 3B0h and 3DFh and their neighbours one address outside. It also exercises dword and word spans that straddle the port pair, and a byte at 21h that sits just below it.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2
   } io_size_e;

   typedef enum logic [1:0] {
      ACC_EXT     = 2'd0,
      ACC_IDX_SET = 2'd1,
      ACC_CFG_RD  = 2'd2,
      ACC_CFG_WR  = 2'd3
   } acc_kind_e;

   localparam logic [7:0] RW_BASE = 8'hC0;
   localparam logic [7:0] ID_LO_NUM = 8'hFE;
   localparam logic [7:0] ID_HI_NUM = 8'hFF;

   // true when a register number selects an on-chip entry
   function automatic logic idx_in_window(input logic [7:0] num, input int unsigned n_rw);
      int unsigned v;
      v = int'(num);
      return ((v >= int'(RW_BASE)) && (v < int'(RW_BASE) + n_rw)) ||
             (num == ID_LO_NUM) || (num == ID_HI_NUM);
   endfunction

endpackage

// File: rtl/cfg_port_classify.sv
module cfg_port_classify
   import cfg_port_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned IDX_PORT  = 'h22,
   parameter int unsigned DATA_PORT = 'h23,
   parameter int unsigned N_RW      = 16,
   parameter bit          HAS_TRAP  = 1'b1,
   parameter int unsigned TRAP_LO   = 'h3B0,
   parameter int unsigned TRAP_HI   = 'h3DF
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              write,
   input  logic [1:0]        size,
   input  logic [7:0]        wdata_lo,
   input  logic              armed,
   output acc_kind_e         kind,
   output logic              fwd_ext,
   output logic              set_arm,
   output logic              clr_arm,
   output logic              trap_hit
);

   localparam int unsigned SPAN_W = ADDR_W + 1;

   logic [SPAN_W-1:0] span_last;
   logic [SPAN_W-1:0] span_add;
   logic              pair_hit;
   logic              is_byte;

   always_comb begin
      unique case (size)
         SZ_BYTE: span_add = SPAN_W'(0);
         SZ_WORD: span_add = SPAN_W'(1);
         default: span_add = SPAN_W'(3);
      endcase
   end

   assign span_last = {1'b0, addr} + span_add;
   assign pair_hit  = ({1'b0, addr} <= SPAN_W'(DATA_PORT)) &&
                      (span_last >= SPAN_W'(IDX_PORT));
   assign is_byte   = (size == SZ_BYTE);

   always_comb begin
      kind = ACC_EXT;
      if (is_byte && write && (addr == ADDR_W'(IDX_PORT)) && idx_in_window(wdata_lo, N_RW))
         kind = ACC_IDX_SET;
      else if (is_byte && armed && (addr == ADDR_W'(DATA_PORT)))
         kind = write ? ACC_CFG_WR : ACC_CFG_RD;
   end

   assign fwd_ext = (kind == ACC_EXT);
   assign set_arm = (kind == ACC_IDX_SET);
   assign clr_arm = pair_hit && !set_arm;

   generate
      if (HAS_TRAP) begin : g_trap
         assign trap_hit = (addr >= ADDR_W'(TRAP_LO)) && (addr <= ADDR_W'(TRAP_HI));
      end else begin : g_no_trap
         assign trap_hit = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cfg_port_regfile.sv
module cfg_port_regfile
   import cfg_port_pkg::*;
#(
   parameter int unsigned N_RW  = 16,
   parameter logic [7:0]  ID_LO = 8'h47,
   parameter logic [7:0]  ID_HI = 8'h31
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);

   generate
      if (N_RW < 1 || N_RW > 16) begin : g_bad_nrw
         $error("cfg_port_regfile: N_RW must be 1..16");
      end
   endgenerate

   logic [7:0] ent_q [N_RW];

   generate
      for (genvar g = 0; g < N_RW; g++) begin : g_ent
         localparam logic [7:0] SLOT_NUM = 8'(int'(RW_BASE) + g);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent_q[g] <= 8'h00;
            else if (wr_en && (idx == SLOT_NUM))
               ent_q[g] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = 8'h00;
      if (idx == ID_LO_NUM)
         rdata = ID_LO;
      else if (idx == ID_HI_NUM)
         rdata = ID_HI;
      else if (idx_in_window(idx, N_RW))
         rdata = ent_q[idx[3:0]];
   end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfg_port_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IDX_PORT  = 'h22,
   parameter int unsigned DATA_PORT = 'h23,
   parameter int unsigned N_RW      = 16,
   parameter logic [7:0]  ID_LO     = 8'h47,
   parameter logic [7:0]  ID_HI     = 8'h31,
   parameter bit          HAS_TRAP  = 1'b1,
   parameter int unsigned TRAP_LO   = 'h3B0,
   parameter int unsigned TRAP_HI   = 'h3DF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [7:0]        req_wdata,
   input  logic              trap_en,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              ext_cycle,
   output logic              trap_flag
);

   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("cfg_index_port: DATA_W must be at least 8");
      end
      if (IDX_PORT == DATA_PORT) begin : g_bad_ports
         $error("cfg_index_port: index and data ports must differ");
      end
      if (TRAP_LO > TRAP_HI) begin : g_bad_trap
         $error("cfg_index_port: empty trap window");
      end
   endgenerate

   acc_kind_e   kind;
   logic        fwd_ext, set_arm, clr_arm, trap_hit;
   logic        armed_q;
   logic [7:0]  idx_q;
   logic [7:0]  rf_rdata;
   logic        rf_wr;

   cfg_port_classify #(
      .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .N_RW(N_RW),
      .HAS_TRAP(HAS_TRAP), .TRAP_LO(TRAP_LO), .TRAP_HI(TRAP_HI)
   ) u_classify (
      .addr(req_addr), .write(req_write), .size(req_size), .wdata_lo(req_wdata),
      .armed(armed_q), .kind(kind), .fwd_ext(fwd_ext), .set_arm(set_arm),
      .clr_arm(clr_arm), .trap_hit(trap_hit)
   );

   assign rf_wr = req_valid && (kind == ACC_CFG_WR);

   cfg_port_regfile #(
      .N_RW(N_RW), .ID_LO(ID_LO), .ID_HI(ID_HI)
   ) u_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(rf_wr), .idx(idx_q),
      .wdata(req_wdata), .rdata(rf_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         idx_q     <= 8'h00;
         ext_cycle <= 1'b0;
         trap_flag <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         ext_cycle <= req_valid && fwd_ext;
         trap_flag <= req_valid && trap_en && trap_hit;
         rsp_rdata <= (req_valid && kind == ACC_CFG_RD) ? DATA_W'(rf_rdata) : '0;
         if (req_valid) begin
            if (set_arm) begin
               armed_q <= 1'b1;
               idx_q   <= req_wdata;
            end else if (clr_arm) begin
               armed_q <= 1'b0;
            end
         end
      end
   end

   // R12: a forwarded cycle flag only follows a real request
   a_r12_ext_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      ext_cycle |-> $past(req_valid));

   // R5: armed byte data-port access stays on chip
   a_r5_cfg_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd0 && req_addr == ADDR_W'(DATA_PORT) && armed_q)
      |=> !ext_cycle);

   // R7: every data-port access consumes the arm
   a_r7_data_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr == ADDR_W'(DATA_PORT)) |=> !armed_q);

   // R4: index reads always go out
   a_r4_idx_read_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == ADDR_W'(IDX_PORT)) |=> ext_cycle);

   // R10: byte requests to other ports keep the arm
   a_r10_other_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd0 && req_addr != ADDR_W'(IDX_PORT) &&
       req_addr != ADDR_W'(DATA_PORT)) |=> $stable(armed_q));

   // R11: the trap flag needs the runtime enable
   a_r11_trap_gated: assert property (@(posedge clk) disable iff (!rst_n)
      trap_flag |-> $past(trap_en && req_valid));

endmodule

// File: tb/cfg_index_port_bench.sv
`timescale 1ns/1ps
module cfg_index_port_bench;

   localparam logic [7:0] B_ID_LO = 8'hA5;
   localparam logic [7:0] B_ID_HI = 8'h17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = '0;
   logic [7:0]  req_wdata = '0;
   logic        trap_en = 1'b0;
   logic [31:0] rsp_rdata;
   logic        ext_cycle;
   logic        trap_flag;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   cfg_index_port #(
      .ID_LO(B_ID_LO), .ID_HI(B_ID_HI), .HAS_TRAP(1'b1)
   ) u_cfg_index_port (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
      .trap_en(trap_en), .rsp_rdata(rsp_rdata), .ext_cycle(ext_cycle),
      .trap_flag(trap_flag)
   );

   typedef struct packed {
      logic [15:0] addr;
      logic        wr;
      logic [1:0]  sz;
      logic        tr;
      logic [7:0]  wd;
      logic        xe;
      logic        xt;
      logic [7:0]  xr;
      logic [3:0]  rq;
   } vec_t;

   function automatic vec_t mk(logic [15:0] a, logic w, logic [1:0] s, logic t,
                               logic [7:0] d, logic e, logic tp, logic [7:0] r,
                               logic [3:0] q);
      return '{addr:a, wr:w, sz:s, tr:t, wd:d, xe:e, xt:tp, xr:r, rq:q};
   endfunction

   localparam int NV = 47;
   localparam vec_t VECS [NV] = '{
      mk(16'h022,1,0,0,8'hC3,0,0,8'h00,2),  // R2 arm C3
      mk(16'h023,1,0,0,8'h5E,0,0,8'h00,5),  // R5 write
      mk(16'h022,1,0,0,8'hC3,0,0,8'h00,2),
      mk(16'h023,0,0,0,8'h00,0,0,8'h5E,5),  // R5 read back
      mk(16'h023,0,0,0,8'h00,1,0,8'h00,6),  // R6 unarmed
      mk(16'h022,1,0,0,8'hC3,0,0,8'h00,2),
      mk(16'h023,1,0,0,8'h11,0,0,8'h00,5),
      mk(16'h023,1,0,0,8'h99,1,0,8'h00,7),  // R7 second access goes out
      mk(16'h022,1,0,0,8'hC3,0,0,8'h00,2),
      mk(16'h023,0,0,0,8'h00,0,0,8'h11,7),  // R7 99 never stored
      mk(16'h022,1,0,0,8'h50,1,0,8'h00,3),  // R3 bad number
      mk(16'h023,0,0,0,8'h00,1,0,8'h00,3),
      mk(16'h022,1,0,0,8'hC3,0,0,8'h00,2),
      mk(16'h022,1,0,0,8'hD0,1,0,8'h00,3),  // R3 disarms
      mk(16'h023,1,0,0,8'h77,1,0,8'h00,3),
      mk(16'h022,1,0,0,8'hC3,0,0,8'h00,3),
      mk(16'h023,0,0,0,8'h00,0,0,8'h11,3),  // R3 77 not stored
      mk(16'h022,1,0,0,8'hC3,0,0,8'h00,4),
      mk(16'h022,0,0,0,8'h00,1,0,8'h00,4),  // R4 index read
      mk(16'h023,0,0,0,8'h00,1,0,8'h00,4),
      mk(16'h022,1,0,0,8'hFE,0,0,8'h00,8),
      mk(16'h023,0,0,0,8'h00,0,0,8'hA5,8),  // R8 ID low
      mk(16'h022,1,0,0,8'hFE,0,0,8'h00,8),
      mk(16'h023,1,0,0,8'h00,0,0,8'h00,8),  // R8 write ignored, internal
      mk(16'h022,1,0,0,8'hFE,0,0,8'h00,8),
      mk(16'h023,0,0,0,8'h00,0,0,8'hA5,8),
      mk(16'h022,1,0,0,8'hFF,0,0,8'h00,8),
      mk(16'h023,0,0,0,8'h00,0,0,8'h17,8),  // R8 ID high
      mk(16'h022,1,0,0,8'hCF,0,0,8'h00,9),
      mk(16'h020,1,2,0,8'hCF,1,0,8'h00,9),  // R9 dword 20..23
      mk(16'h023,0,0,0,8'h00,1,0,8'h00,9),
      mk(16'h022,1,0,0,8'hCF,0,0,8'h00,9),
      mk(16'h022,1,1,0,8'hCF,1,0,8'h00,9),  // R9 word at 22
      mk(16'h023,0,0,0,8'h00,1,0,8'h00,9),
      mk(16'h022,1,0,0,8'hCF,0,0,8'h00,10),
      mk(16'h080,1,0,0,8'h33,1,0,8'h00,10), // R10 other port
      mk(16'h021,0,0,0,8'h00,1,0,8'h00,10), // R10 just below pair
      mk(16'h023,1,0,0,8'h42,0,0,8'h00,10),
      mk(16'h022,1,0,0,8'hCF,0,0,8'h00,10),
      mk(16'h023,0,0,0,8'h00,0,0,8'h42,10),
      mk(16'h3B0,0,0,1,8'h00,1,1,8'h00,11), // R11 low edge
      mk(16'h3DF,1,0,1,8'h00,1,1,8'h00,11), // R11 high edge
      mk(16'h3AF,0,0,1,8'h00,1,0,8'h00,11),
      mk(16'h3E0,0,0,1,8'h00,1,0,8'h00,11),
      mk(16'h3C0,0,0,0,8'h00,1,0,8'h00,11), // R11 disabled
      mk(16'h022,1,0,0,8'hC0,0,0,8'h00,2),
      mk(16'h023,0,0,0,8'h00,0,0,8'h00,1)   // R1 untouched entry reads 00
   };

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_req(logic [15:0] a, logic w, logic [1:0] s, logic t, logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w; req_size = s;
      req_wdata = d; trap_en = t;
      @(negedge clk);
      req_valid = 1'b0; trap_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset outputs
      check("R1", "ext_cycle", 32'(ext_cycle), 32'h0);
      check("R1", "trap_flag", 32'(trap_flag), 32'h0);
      check("R1", "rsp_rdata", rsp_rdata, 32'h0);
      // R1 reset leaves data port unarmed
      do_req(16'h023, 1'b0, 2'd0, 1'b0, 8'h00);
      check("R1", "unarmed ext", 32'(ext_cycle), 32'h1);

      for (int i = 0; i < NV; i++) begin
         string rs;
         rs = $sformatf("R%0d", VECS[i].rq);
         do_req(VECS[i].addr, VECS[i].wr, VECS[i].sz, VECS[i].tr, VECS[i].wd);
         check(rs, $sformatf("vec%0d ext_cycle", i), 32'(ext_cycle), 32'(VECS[i].xe));
         check(rs, $sformatf("vec%0d trap_flag", i), 32'(trap_flag), 32'(VECS[i].xt));
         check(rs, $sformatf("vec%0d rsp_rdata", i), rsp_rdata, {24'h0, VECS[i].xr});
         @(negedge clk);
         // R12 flag lasts a single cycle
         check("R12", $sformatf("vec%0d ext idle", i), 32'(ext_cycle), 32'h0);
      end

      // R1 mid-run reset clears a written entry
      do_req(16'h022, 1'b1, 2'd0, 1'b0, 8'hC7);
      do_req(16'h023, 1'b1, 2'd0, 1'b0, 8'hEE);
      do_req(16'h022, 1'b1, 2'd0, 1'b0, 8'hC7);
      do_req(16'h023, 1'b0, 2'd0, 1'b0, 8'h00);
      check("R5", "C7 before reset", rsp_rdata, 32'h0000_00EE);
      do_req(16'h022, 1'b1, 2'd0, 1'b0, 8'hC7);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_req(16'h023, 1'b0, 2'd0, 1'b0, 8'h00);
      check("R1", "arm cleared by reset", 32'(ext_cycle), 32'h1);
      do_req(16'h022, 1'b1, 2'd0, 1'b0, 8'hC7);
      do_req(16'h023, 1'b0, 2'd0, 1'b0, 8'h00);
      check("R1", "C7 after reset", rsp_rdata, 32'h0);
      check("R5", "internal read no ext", 32'(ext_cycle), 32'h0);

      // R9 dword at 21 overlaps pair; dword at 1E does not
      do_req(16'h022, 1'b1, 2'd0, 1'b0, 8'hC1);
      do_req(16'h01E, 1'b0, 2'd2, 1'b0, 8'h00);
      check("R10", "dword 1E ext", 32'(ext_cycle), 32'h1);
      do_req(16'h023, 1'b1, 2'd0, 1'b0, 8'h6D);
      check("R10", "arm kept past 1E", 32'(ext_cycle), 32'h0);
      do_req(16'h022, 1'b1, 2'd0, 1'b0, 8'hC1);
      do_req(16'h021, 1'b0, 2'd2, 1'b0, 8'h00);
      check("R9", "dword 21 ext", 32'(ext_cycle), 32'h1);
      do_req(16'h023, 1'b0, 2'd0, 1'b0, 8'h00);
      check("R9", "disarmed by dword 21", 32'(ext_cycle), 32'h1);
      do_req(16'h022, 1'b1, 2'd0, 1'b0, 8'hC1);
      do_req(16'h023, 1'b0, 2'd0, 1'b0, 8'h00);
      check("R5", "C1 value", rsp_rdata, 32'h0000_006D);

      finish_run();
   end

endmodule